// File: doc/BRIEF.md
# Segment Load Privilege Checker

This block decides whether a segment selector may be placed in a segment register under ring-protection rules. The caller presents the current ring, the ring requested by the selector, the ring and kind of the descriptor the selector names, which register is being loaded, whether the core runs in 64-bit mode, and whether the selector is null. One clock after a load strobe the block returns either an accept or a general-protection fault. A fault carries a cause code.

Each target register has its own rule. The stack register needs all three rings to be equal and a writable data descriptor. The ordinary data registers use a relaxed rule: a more privileged caller may use a less privileged data segment. The code register needs an exact ring match for non-conforming code and allows a higher ring for conforming code. Null selectors are handled before any descriptor field is consulted. The descriptor fetch, limit checks, gates and task switches happen elsewhere.

Top module: `seg_load_chk`

## Requirements
- R1: On reset every output is 0. One clock edge after the edge that samples `load_req`=1, `res_valid` is 1 for one cycle. At that point the other outputs hold the decision, and they keep it until the next request.
- R2: Every decision has exactly one of `res_ok` or `res_fault` at 1. `res_cause` is 0 exactly when `res_ok` is 1. Cause codes are: 1 null stack, 2 privilege, 3 type, 4 not writable.
- R3: For a non-null selector with the stack target (`target`=2'b01), the privilege check passes only when `cur_pl`, `req_pl` and `desc_pl` are all equal. Otherwise the fault has cause 2.
- R4: For a non-null selector with the data target (`target`=2'b00), the privilege check passes when max(`cur_pl`,`req_pl`) <= `desc_pl`. Otherwise the fault has cause 2.
- R5: For the code target (`target[1]`=1), `req_pl` is ignored. Non-conforming code needs `desc_pl`==`cur_pl`. Conforming code (`desc_conforming`=1) needs `desc_pl`<=`cur_pl`. A failure gives cause 2.
- R6: A null selector loaded into the stack target faults with cause 1 when `mode64`=0. When `mode64`=1 it is accepted with `res_unusable`=1.
- R7: A null selector loaded into the data target is accepted with `res_unusable`=1 in either mode. A null selector loaded into the code target faults with cause 3. `res_unusable` is 0 for every non-null accept.
- R8: The stack and data targets need `desc_is_code`=0, and the code target needs `desc_is_code`=1. A mismatch gives cause 3.
- R9: A stack target load needs `desc_writable`=1, or it faults with cause 4. The data and code targets ignore `desc_writable`.
- R10: When several rules fail, the reported cause is the first in this order: null stack, privilege, type, not writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_req | input | 1 | Strobe: evaluate the presented load |
| cur_pl | input | 2 | Current privilege ring (0 most privileged) |
| req_pl | input | 2 | Requested ring carried by the selector |
| desc_pl | input | 2 | Descriptor ring |
| desc_is_code | input | 1 | Descriptor is a code segment |
| desc_conforming | input | 1 | Code descriptor is conforming |
| desc_writable | input | 1 | Data descriptor is writable |
| target | input | 2 | 00 data, 01 stack, 1x code |
| mode64 | input | 1 | Core runs in 64-bit mode |
| sel_null | input | 1 | Selector is null |
| res_valid | output | 1 | Decision registered this cycle |
| res_ok | output | 1 | Load accepted |
| res_fault | output | 1 | General-protection fault |
| res_cause | output | 3 | Fault cause code |
| res_unusable | output | 1 | Accepted null selector; register marked unusable |

## Verification
Every decision appears one clock after the request edge, and `res_valid` falls on the clock after that. The bench sets up each load on a falling edge and reads the results on the next falling edge, which is one rising edge later. On the falling edge after that, with the strobe low, it checks that `res_valid` has dropped and that the decision has not moved. The property checks use the same one-cycle offset: they relate the inputs at a request to the outputs on the following cycle.

// File: rtl/seg_load_chk.sv
module seg_load_chk #(
  parameter int PL_W    = 2,
  parameter int CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_req,
  input  logic [PL_W-1:0]    cur_pl,
  input  logic [PL_W-1:0]    req_pl,
  input  logic [PL_W-1:0]    desc_pl,
  input  logic               desc_is_code,
  input  logic               desc_conforming,
  input  logic               desc_writable,
  input  logic [1:0]         target,
  input  logic               mode64,
  input  logic               sel_null,
  output logic               res_valid,
  output logic               res_ok,
  output logic               res_fault,
  output logic [CAUSE_W-1:0] res_cause,
  output logic               res_unusable
);

  localparam logic [CAUSE_W-1:0] C_NONE  = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] C_NULSS = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] C_PRIV  = CAUSE_W'(2);
  localparam logic [CAUSE_W-1:0] C_TYPE  = CAUSE_W'(3);
  localparam logic [CAUSE_W-1:0] C_NOWR  = CAUSE_W'(4);

  wire is_stk  = (target == 2'b01);
  wire is_code = target[1];

  wire [PL_W-1:0] eff_pl = (cur_pl > req_pl) ? cur_pl : req_pl;

  wire stk_priv  = (cur_pl == req_pl) && (req_pl == desc_pl);
  wire code_priv = desc_conforming ? (desc_pl <= cur_pl) : (desc_pl == cur_pl);
  wire data_priv = (eff_pl <= desc_pl);

  wire priv_ok = is_stk ? stk_priv : (is_code ? code_priv : data_priv);
  wire type_ok = is_code ? desc_is_code : !desc_is_code;
  wire wr_ok   = !is_stk || desc_writable;

  logic [CAUSE_W-1:0] cause_n;

  always_comb begin
    if (sel_null) begin
      if (is_stk && !mode64) cause_n = C_NULSS;
      else if (is_code)      cause_n = C_TYPE;
      else                   cause_n = C_NONE;
    end else if (!priv_ok)   cause_n = C_PRIV;
    else if (!type_ok)       cause_n = C_TYPE;
    else if (!wr_ok)         cause_n = C_NOWR;
    else                     cause_n = C_NONE;
  end

  wire accept_n = (cause_n == C_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_ok       <= 1'b0;
      res_fault    <= 1'b0;
      res_cause    <= C_NONE;
      res_unusable <= 1'b0;
    end else begin
      res_valid <= load_req;
      if (load_req) begin
        res_ok       <= accept_n;
        res_fault    <= !accept_n;
        res_cause    <= cause_n;
        res_unusable <= accept_n && sel_null;
      end
    end
  end

endmodule

// File: rtl/seg_load_chk_sva.sv
module seg_load_chk_sva #(
  parameter int PL_W    = 2,
  parameter int CAUSE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_req,
  input logic [PL_W-1:0]    cur_pl,
  input logic [PL_W-1:0]    req_pl,
  input logic [PL_W-1:0]    desc_pl,
  input logic [1:0]         target,
  input logic               mode64,
  input logic               sel_null,
  input logic               res_valid,
  input logic               res_ok,
  input logic               res_fault,
  input logic [CAUSE_W-1:0] res_cause,
  input logic               res_unusable
);

  // R1
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> res_valid);

  // R1
  hold_between_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> (!res_valid && $stable({res_ok, res_fault, res_cause, res_unusable})));

  // R2
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_ok, res_fault}) == 1 && (res_ok == (res_cause == '0))));

  // R3
  stack_ring_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && target == 2'b01 && !sel_null && !(cur_pl == req_pl && req_pl == desc_pl))
      |=> (res_fault && res_cause == CAUSE_W'(2)));

  // R6
  null_stack_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && target == 2'b01 && sel_null && !mode64) |=> (res_fault && res_cause == CAUSE_W'(1)));

  // R7
  null_data_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && target == 2'b00 && sel_null) |=> (res_ok && res_unusable));

  // R7
  unusable_only_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !sel_null) |=> !res_unusable);

endmodule

bind seg_load_chk seg_load_chk_sva #(.PL_W(PL_W), .CAUSE_W(CAUSE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .load_req(load_req), .cur_pl(cur_pl), .req_pl(req_pl),
  .desc_pl(desc_pl), .target(target), .mode64(mode64), .sel_null(sel_null),
  .res_valid(res_valid), .res_ok(res_ok), .res_fault(res_fault),
  .res_cause(res_cause), .res_unusable(res_unusable));

// File: tb/seg_load_chk_tb.sv
module seg_load_chk_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_req = 1'b0;
  logic [1:0] cur_pl = '0, req_pl = '0, desc_pl = '0, target = '0;
  logic desc_is_code = 1'b0, desc_conforming = 1'b0, desc_writable = 1'b0;
  logic mode64 = 1'b0, sel_null = 1'b0;
  logic res_valid, res_ok, res_fault, res_unusable;
  logic [2:0] res_cause;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_load_chk u_dut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .cur_pl(cur_pl), .req_pl(req_pl),
    .desc_pl(desc_pl), .desc_is_code(desc_is_code), .desc_conforming(desc_conforming),
    .desc_writable(desc_writable), .target(target), .mode64(mode64), .sel_null(sel_null),
    .res_valid(res_valid), .res_ok(res_ok), .res_fault(res_fault),
    .res_cause(res_cause), .res_unusable(res_unusable));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  localparam logic [1:0] T_DATA = 2'b00, T_STK = 2'b01, T_CODE = 2'b10;

  task automatic load(string tag, logic [1:0] tg, logic [1:0] c, logic [1:0] r, logic [1:0] d,
                      logic code, logic conf, logic wr, logic m64, logic nul,
                      logic exp_ok, int exp_cause, logic exp_unus);
    @(negedge clk);
    target = tg; cur_pl = c; req_pl = r; desc_pl = d;
    desc_is_code = code; desc_conforming = conf; desc_writable = wr;
    mode64 = m64; sel_null = nul; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    check({tag, " R1 valid"}, res_valid, 1);
    check({tag, " R2 ok"}, res_ok, exp_ok);
    check({tag, " R2 fault"}, res_fault, !exp_ok);
    check({tag, " cause"}, res_cause, exp_cause);
    check({tag, " unusable"}, res_unusable, exp_unus);
    // R1: hold with strobe low, inputs perturbed
    target = ~tg; sel_null = ~nul; cur_pl = ~c;
    @(negedge clk);
    check({tag, " R1 valid drop"}, res_valid, 0);
    check({tag, " R1 hold"}, {res_ok, res_fault, res_cause, res_unusable},
          {exp_ok, !exp_ok, 3'(exp_cause), exp_unus});
  endtask

  task automatic t_reset;
    #1;
    check("R1 reset valid", res_valid, 0);
    check("R1 reset ok", res_ok, 0);
    check("R1 reset fault", res_fault, 0);
    check("R1 reset cause", res_cause, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_stack;
    load("R3 all0",        T_STK, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0);
    load("R3 all3",        T_STK, 3, 3, 3, 0, 0, 1, 0, 0, 1, 0, 0);
    load("R3 dpl differs", T_STK, 0, 0, 3, 0, 0, 1, 0, 0, 0, 2, 0);
    load("R3 rpl differs", T_STK, 3, 0, 3, 0, 0, 1, 0, 0, 0, 2, 0);
  endtask

  task automatic t_data;
    load("R4 ring0 uses dpl3", T_DATA, 0, 0, 3, 0, 0, 1, 0, 0, 1, 0, 0);
    load("R4 cpl above dpl",   T_DATA, 3, 0, 0, 0, 0, 1, 0, 0, 0, 2, 0);
    load("R4 rpl above dpl",   T_DATA, 0, 3, 2, 0, 0, 1, 0, 0, 0, 2, 0);
    load("R4 max equal",       T_DATA, 1, 2, 2, 0, 0, 1, 0, 0, 1, 0, 0);
  endtask

  task automatic t_code;
    load("R5 nonconf eq rpl ignored", T_CODE, 2, 3, 2, 1, 0, 0, 0, 0, 1, 0, 0);
    load("R5 nonconf differs",        T_CODE, 0, 0, 3, 1, 0, 0, 0, 0, 0, 2, 0);
    load("R5 conf lower dpl",         T_CODE, 3, 3, 0, 1, 1, 0, 0, 0, 1, 0, 0);
    load("R5 conf higher dpl",        T_CODE, 0, 0, 3, 1, 1, 0, 0, 0, 0, 2, 0);
  endtask

  task automatic t_null;
    load("R6 null stack legacy", T_STK,  0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0);
    load("R6 null stack 64",     T_STK,  0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 1);
    load("R7 null data",         T_DATA, 3, 3, 0, 1, 0, 0, 0, 1, 1, 0, 1);
    load("R7 null code",         T_CODE, 0, 0, 0, 1, 0, 0, 1, 1, 0, 3, 0);
  endtask

  task automatic t_type_wr;
    load("R8 code into data", T_DATA, 0, 0, 0, 1, 0, 1, 0, 0, 0, 3, 0);
    load("R8 data into code", T_CODE, 0, 0, 0, 0, 0, 1, 0, 0, 0, 3, 0);
    load("R9 stack readonly", T_STK,  2, 2, 2, 0, 0, 0, 0, 0, 0, 4, 0);
    load("R9 data readonly",  T_DATA, 2, 2, 2, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_priority;
    load("R10 null beats priv",  T_STK, 0, 3, 1, 1, 0, 0, 0, 1, 0, 1, 0);
    load("R10 priv beats type",  T_STK, 0, 1, 0, 1, 0, 0, 0, 0, 0, 2, 0);
    load("R10 type beats write", T_STK, 1, 1, 1, 1, 0, 0, 0, 0, 0, 3, 0);
  endtask

  initial begin
    t_reset();
    t_stack();
    t_data();
    t_code();
    t_null();
    t_type_wr();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule